// File: doc/BRIEF.md
# UART FIFO Level Interrupt Trigger

This block produces the receive and transmit interrupt requests of a UART from the occupancy counts of its receive and transmit FIFOs. A 32-bit control register holds two 3-bit threshold codes. The receive request is raised when the receive FIFO fills up to the selected level. The transmit request is raised when the transmit FIFO drains down to the selected level. Both levels are fractions of the FIFO depth, which is 16 entries by default.

An end-of-transmission input changes what the transmit request waits for. While it is high, the transmit threshold code is ignored. The request then waits until the transmit FIFO is empty and the serializer reports that it is no longer busy, which means the final stop bit has left the line.

Each request is a sticky flag. It is set on the one clock edge where its condition first becomes true, and it stays set until its own clear strobe removes it.

Three instances of a two-state zone watcher detect when a condition becomes true. Their states are `ZONE_OUT` and `ZONE_IN`:
- A watcher moves from `ZONE_OUT` to `ZONE_IN` when its condition becomes true. That transition is the entry event.
- It moves from `ZONE_IN` back to `ZONE_OUT` when the condition goes false.

Two instances of a flag machine hold the interrupt requests. Their states are `FLAG_IDLE` and `FLAG_PEND`:
- An entry event moves the flag to `FLAG_PEND`.
- A clear strobe moves it back to `FLAG_IDLE`.
- When an entry event and a clear strobe arrive together, the flag stays in `FLAG_PEND`.

Top module: `uart_lvl_irq`

## Requirements
- R1: Control register bits [2:0] hold the transmit code and bits [5:3] hold the receive code. A write takes effect on the next clock edge. Bits [31:6] always read back as 0, and the register resets to 0.
- R2: A code of 5, 6 or 7 in either field reads back exactly as it was written. It behaves as code 2, which is half depth (8 entries).
- R3: The receive flag sets on the edge where `rx_count >= level` first holds. The level is depth × 1/8, 2/8, 4/8, 6/8 or 7/8 for codes 0 to 4, which gives 2, 4, 8, 12 and 14 entries at the default depth.
- R4: With end-of-transmission mode off, the transmit flag sets on the edge where `tx_count <= level` first holds. It uses the same level table as R3, with the transmit code.
- R5: A flag does not set again while its condition simply stays true. It can only set again after the condition has gone false and then become true once more.
- R6: A clear strobe resets its flag on the next edge. If the flag's set event happens on the same edge as the clear, the flag stays set.
- R7: With end-of-transmission mode on, the transmit threshold code has no effect. The transmit flag sets on the edge where `tx_count == 0 && !ser_busy` first holds.
- R8: Coming out of reset, the transmit level condition and the idle condition count as already true, and the receive condition counts as false. An empty transmit FIFO right after reset therefore raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control register write enable |
| reg_wdata | input | 32 | Control register write data |
| reg_rdata | output | 32 | Control register readback |
| rx_count | input | 5 | Receive FIFO occupancy, from 0 to 16 |
| tx_count | input | 5 | Transmit FIFO occupancy, from 0 to 16 |
| ser_busy | input | 1 | High while the serializer is shifting a frame out |
| eot_mode | input | 1 | End-of-transmission mode select |
| rx_clr | input | 1 | Clear strobe for the receive flag |
| tx_clr | input | 1 | Clear strobe for the transmit flag |
| rx_irq | output | 1 | Sticky receive interrupt request |
| tx_irq | output | 1 | Sticky transmit interrupt request |

## Verification
The assertions check the following on every cycle:
- Readback of the low six bits after each write.
- The half-depth fallback for reserved codes.
- The set, clear and hold priority of each flag.
- That a fresh entry into a level or idle condition leads to a raised flag.

Some behaviours only the bench scenarios can show. These are the exact trigger points for every code, and the silence right after reset with an empty transmit FIFO. They also include the threshold field having no effect in end-of-transmission mode, and the absence of re-triggering while a level is held. The bench shows them by running directed walks through the levels, followed by a long random run checked against an independent model.

// File: rtl/uart_lvl_pkg.sv
`timescale 1ns/1ps
package uart_lvl_pkg;

    typedef enum logic {
        ZONE_OUT = 1'b0,
        ZONE_IN  = 1'b1
    } zone_e;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_e;

    localparam int unsigned SEL_W        = 3;
    localparam int unsigned NUM_CODES    = 5;
    localparam logic [SEL_W-1:0] SEL_FALLBACK = 3'd2;

    // Trigger level in entries for a legal code, given the FIFO depth.
    function automatic int unsigned level_of(input logic [SEL_W-1:0] code,
                                             input int unsigned depth);
        case (code)
            3'd0:    return depth / 8;
            3'd1:    return depth / 4;
            3'd2:    return depth / 2;
            3'd3:    return (depth * 3) / 4;
            3'd4:    return (depth * 7) / 8;
            default: return depth / 2;
        endcase
    endfunction

endpackage

// File: rtl/lvl_ctrl_reg.sv
`timescale 1ns/1ps
module lvl_ctrl_reg
    import uart_lvl_pkg::*;
#(
    parameter int unsigned REG_W  = 32,
    parameter int unsigned NFIELD = 2,
    localparam int unsigned FW    = NFIELD * SEL_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [REG_W-1:0]             wr_data,
    output logic [REG_W-1:0]             rd_data,
    output logic [NFIELD-1:0][SEL_W-1:0] eff_sel
);

    logic [FW-1:0] raw_q;
    logic          unused_hi;

    assign unused_hi = ^wr_data[REG_W-1:FW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else if (wr_en) begin
            raw_q <= wr_data[FW-1:0];
        end
    end

    assign rd_data = {{(REG_W-FW){1'b0}}, raw_q};

    for (genvar f = 0; f < NFIELD; f++) begin : g_field
        logic [SEL_W-1:0] raw_f;
        assign raw_f      = raw_q[f*SEL_W +: SEL_W];
        assign eff_sel[f] = (raw_f >= SEL_W'(NUM_CODES)) ? SEL_FALLBACK : raw_f;

        // R2: a reserved code never reaches the decoder
        a_r2_fallback: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[f*SEL_W +: SEL_W] >= SEL_W'(NUM_CODES)) |-> (eff_sel[f] == SEL_FALLBACK));
    end

    // R1: a write lands in the readback one edge later
    a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en)) |-> (rd_data[FW-1:0] == $past(wr_data[FW-1:0])));

endmodule

// File: rtl/lvl_zone_fsm.sv
`timescale 1ns/1ps
module lvl_zone_fsm
    import uart_lvl_pkg::*;
#(
    parameter bit RESET_IN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic entered
);

    localparam zone_e RST_STATE = RESET_IN ? ZONE_IN : ZONE_OUT;

    zone_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RST_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ZONE_OUT: if (cond)  state_d = ZONE_IN;
            ZONE_IN:  if (!cond) state_d = ZONE_OUT;
        endcase
    end

    always_comb begin
        entered = 1'b0;
        unique case (state_q)
            ZONE_OUT: entered = cond;
            ZONE_IN:  entered = 1'b0;
        endcase
    end

    // R5: an entry event is a single-cycle pulse
    a_r5_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
        entered |=> !entered);

    // R5: holding the condition never produces a new entry
    a_r5_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cond) && cond) |-> !entered);

endmodule

// File: rtl/lvl_irq_flag.sv
`timescale 1ns/1ps
module lvl_irq_flag
    import uart_lvl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    flag_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (set)         state_d = FLAG_PEND;
            FLAG_PEND: if (clr && !set) state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        flag = 1'b0;
        unique case (state_q)
            FLAG_IDLE: flag = 1'b0;
            FLAG_PEND: flag = 1'b1;
        endcase
    end

    // R6: set wins over clear
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);

    // R6: a lone clear drops the flag
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);

    // R5: without set or clear the flag is sticky
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !set) |=> $stable(flag));

endmodule

// File: rtl/uart_lvl_irq.sv
`timescale 1ns/1ps
module uart_lvl_irq
    import uart_lvl_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned REG_W = 32,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [CW-1:0]    rx_count,
    input  logic [CW-1:0]    tx_count,
    input  logic             ser_busy,
    input  logic             eot_mode,
    input  logic             rx_clr,
    input  logic             tx_clr,
    output logic             rx_irq,
    output logic             tx_irq
);

    localparam int unsigned TX_F = 0;
    localparam int unsigned RX_F = 1;

    logic [1:0][SEL_W-1:0] eff_sel;
    logic [CW-1:0]         rx_lvl, tx_lvl;
    logic                  rx_in, tx_in, tx_idle;
    logic                  rx_hit, tx_lvl_hit, idle_hit, tx_set;

    lvl_ctrl_reg #(.REG_W(REG_W), .NFIELD(2)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_data (reg_wdata),
        .rd_data (reg_rdata),
        .eff_sel (eff_sel)
    );

    assign rx_lvl  = CW'(level_of(eff_sel[RX_F], DEPTH));
    assign tx_lvl  = CW'(level_of(eff_sel[TX_F], DEPTH));
    assign rx_in   = (rx_count >= rx_lvl);
    assign tx_in   = (tx_count <= tx_lvl);
    assign tx_idle = (tx_count == '0) && !ser_busy;

    lvl_zone_fsm #(.RESET_IN(1'b0)) u_rx_zone (
        .clk (clk), .rst_n (rst_n), .cond (rx_in), .entered (rx_hit)
    );

    lvl_zone_fsm #(.RESET_IN(1'b1)) u_tx_zone (
        .clk (clk), .rst_n (rst_n), .cond (tx_in), .entered (tx_lvl_hit)
    );

    lvl_zone_fsm #(.RESET_IN(1'b1)) u_idle_zone (
        .clk (clk), .rst_n (rst_n), .cond (tx_idle), .entered (idle_hit)
    );

    assign tx_set = eot_mode ? idle_hit : tx_lvl_hit;

    lvl_irq_flag u_rx_flag (
        .clk (clk), .rst_n (rst_n), .set (rx_hit), .clr (rx_clr), .flag (rx_irq)
    );

    lvl_irq_flag u_tx_flag (
        .clk (clk), .rst_n (rst_n), .set (tx_set), .clr (tx_clr), .flag (tx_irq)
    );

    // R3: first cycle at or above the receive level raises the flag
    a_r3_rx_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rx_in && !$past(rx_in)) |=> rx_irq);

    // R4: first cycle at or below the transmit level raises the flag
    a_r4_tx_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (!eot_mode && $past(rst_n) && tx_in && !$past(tx_in)) |=> tx_irq);

    // R7: serializer going idle with an empty FIFO raises the flag
    a_r7_eot_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_mode && $past(rst_n) && tx_idle && !$past(tx_idle)) |=> tx_irq);

    // R7: in this mode a level entry alone never sets the flag
    a_r7_level_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_mode && !tx_irq && !idle_hit) |=> !tx_irq);

endmodule

// File: tb/test_uart_lvl_irq.sv
`timescale 1ns/1ps
module test_uart_lvl_irq;

    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [CW-1:0] rx_count = '0;
    logic [CW-1:0] tx_count = '0;
    logic          ser_busy = 1'b0;
    logic          eot_mode = 1'b0;
    logic          rx_clr = 1'b0;
    logic          tx_clr = 1'b0;
    logic          rx_irq, tx_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // model state
    logic [2:0] m_tx_sel, m_rx_sel;
    bit m_rx_prev, m_tx_prev, m_idle_prev, m_rx_irq, m_tx_irq;

    always #5 clk = ~clk;

    uart_lvl_irq i_uart_lvl_irq (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata), .rx_count (rx_count), .tx_count (tx_count),
        .ser_busy (ser_busy), .eot_mode (eot_mode), .rx_clr (rx_clr),
        .tx_clr (tx_clr), .rx_irq (rx_irq), .tx_irq (tx_irq)
    );

    function automatic int lvl(input logic [2:0] code);
        case (code)
            3'd0: return 2;
            3'd1: return 4;
            3'd3: return 12;
            3'd4: return 14;
            default: return 8;
        endcase
    endfunction

    function automatic logic [31:0] exp_rdata();
        return {26'd0, m_rx_sel, m_tx_sel};
    endfunction

    task automatic model_reset();
        m_tx_sel = 0; m_rx_sel = 0;
        m_rx_prev = 0; m_tx_prev = 1; m_idle_prev = 1;
        m_rx_irq = 0; m_tx_irq = 0;
    endtask

    task automatic model_step();
        bit rx_in, tx_in, idle, rx_hit, tx_hit;
        rx_in  = int'(rx_count) >= lvl(m_rx_sel);
        tx_in  = int'(tx_count) <= lvl(m_tx_sel);
        idle   = (tx_count == 0) && !ser_busy;
        rx_hit = rx_in && !m_rx_prev;
        tx_hit = eot_mode ? (idle && !m_idle_prev) : (tx_in && !m_tx_prev);
        m_rx_irq = rx_hit ? 1'b1 : (rx_clr ? 1'b0 : m_rx_irq);
        m_tx_irq = tx_hit ? 1'b1 : (tx_clr ? 1'b0 : m_tx_irq);
        m_rx_prev = rx_in; m_tx_prev = tx_in; m_idle_prev = idle;
        if (reg_wr) begin
            m_tx_sel = reg_wdata[2:0];
            m_rx_sel = reg_wdata[5:3];
        end
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "reg_rdata", reg_rdata, exp_rdata());
        check(tag, "rx_irq", 32'(rx_irq), 32'(m_rx_irq));
        check(tag, "tx_irq", 32'(tx_irq), 32'(m_tx_irq));
    endtask

    // caller is at a negedge with inputs set
    task automatic step(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic write_reg(input logic [31:0] v, input string tag);
        reg_wr = 1; reg_wdata = v;
        step(tag);
        reg_wr = 0;
    endtask

    task automatic clear_both(input string tag);
        rx_clr = 1; tx_clr = 1;
        step(tag);
        rx_clr = 0; tx_clr = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(negedge clk);
        compare("R1");               // reset readback and idle flags
        rst_n = 1;
        // R8: empty transmit FIFO right after reset raises nothing
        repeat (3) step("R8");
        check("R8", "tx_irq after reset", 32'(tx_irq), 32'd0);

        // R1: reserved upper bits read as zero
        write_reg(32'hFFFF_FFFF, "R1");
        check("R1", "readback", reg_rdata, 32'h0000_003F);
        clear_both("R1");

        // R2: codes 7/7 behave as half depth
        tx_count = 16; step("R2");
        rx_count = 7;  step("R2");
        check("R2", "rx_irq below 8", 32'(rx_irq), 32'd0);
        rx_count = 8;  step("R2");
        check("R2", "rx_irq at 8", 32'(rx_irq), 32'd1);
        tx_count = 9;  step("R2");
        check("R2", "tx_irq at 9", 32'(tx_irq), 32'd0);
        tx_count = 8;  step("R2");
        check("R2", "tx_irq at 8", 32'(tx_irq), 32'd1);
        clear_both("R2");

        // R3: every receive code, walk up from empty
        for (int c = 0; c < 5; c++) begin
            rx_count = 0;
            write_reg({26'd0, 3'(c), 3'd7}, "R3");
            step("R3");
            clear_both("R3");
            for (int n = 1; n <= 16; n++) begin
                rx_count = CW'(n);
                step("R3");
            end
            check("R3", "rx_irq after walk", 32'(rx_irq), 32'd1);
        end
        rx_count = 0;

        // R4: every transmit code, walk down from full
        for (int c = 0; c < 5; c++) begin
            tx_count = 16;
            write_reg({26'd0, 3'd2, 3'(c)}, "R4");
            step("R4");
            clear_both("R4");
            for (int n = 15; n >= 0; n--) begin
                tx_count = CW'(n);
                step("R4");
            end
            check("R4", "tx_irq after walk", 32'(tx_irq), 32'd1);
        end

        // R5: hold inside the region, clear, no re-trigger
        write_reg(32'h0000_0010, "R5");   // rx code 2, tx code 0
        rx_count = 12; step("R5");
        clear_both("R5");
        repeat (4) step("R5");
        check("R5", "rx_irq held level", 32'(rx_irq), 32'd0);
        rx_count = 3; step("R5");
        rx_count = 9; step("R5");
        check("R5", "rx_irq re-entry", 32'(rx_irq), 32'd1);

        // R6: clear on the same edge as a new entry keeps the flag
        rx_count = 2; step("R6");
        rx_count = 8; rx_clr = 1; step("R6");
        rx_clr = 0;
        check("R6", "rx_irq set vs clear", 32'(rx_irq), 32'd1);
        rx_clr = 1; step("R6"); rx_clr = 0;
        check("R6", "rx_irq cleared", 32'(rx_irq), 32'd0);

        // R7: end-of-transmission mode ignores the level code
        tx_count = 16; ser_busy = 1; step("R7");
        clear_both("R7");
        eot_mode = 1;
        write_reg(32'h0000_0004, "R7");   // tx code 4 (14)
        for (int n = 15; n >= 0; n--) begin
            tx_count = CW'(n);
            step("R7");
        end
        check("R7", "tx_irq while busy", 32'(tx_irq), 32'd0);
        ser_busy = 0; step("R7");
        check("R7", "tx_irq at idle", 32'(tx_irq), 32'd1);
        eot_mode = 0;
        clear_both("R7");

        // random mix checked against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 3) == 0) rx_count = CW'($urandom_range(0, 16));
            else if ($urandom_range(0, 1) == 1 && rx_count < 16) rx_count = rx_count + 1'b1;
            else if (rx_count > 0) rx_count = rx_count - 1'b1;
            if ($urandom_range(0, 3) == 0) tx_count = CW'($urandom_range(0, 16));
            else if ($urandom_range(0, 1) == 1 && tx_count < 16) tx_count = tx_count + 1'b1;
            else if (tx_count > 0) tx_count = tx_count - 1'b1;
            ser_busy  = ($urandom_range(0, 2) != 0);
            if ($urandom_range(0, 49) == 0) eot_mode = ~eot_mode;
            reg_wr    = ($urandom_range(0, 19) == 0);
            reg_wdata = $urandom();
            rx_clr    = ($urandom_range(0, 5) == 0);
            tx_clr    = ($urandom_range(0, 5) == 0);
            step("R3/R4/R6/R7");
        end
        reg_wr = 0; rx_clr = 0; tx_clr = 0;

        finished = 1;
        summary();
        $finish;
    end

endmodule